// File: doc/BRIEF.md
# Two-Channel Bus Break Comparator

This block snoops two on-chip bus ports, bus 0 and bus 1, and raises a one-cycle break request toward the processor when a programmed condition matches a bus cycle. Two channels, A and B, each hold a target address, an address don't-care mask and a cycle qualifier. The qualifier picks which bus port is watched, whether instruction fetches or data accesses count, and whether reads or writes count. Channel B also compares the bus data against a target value under its own don't-care mask.

Each match sets a sticky flag that records both the channel and the bus port. Software reads the flags through a small register port and clears single flags by writing zero to them. When matches arrive close together, for example a data access caught by one channel and the following fetch caught by the other, only one request is sent, but every matching channel still records its flag. All registers reset to zero, so both channels start disarmed.

Top module: `bus_break_unit`

## Requirements
- R1: After reset every register reads as zero and `brk_req` is low.
- R2: A channel's address matches when the bus address equals the target address in every bit whose address-mask bit is 0. Mask bits set to 1 are don't-care.
- R3: The qualifier is 6 bits. Bits [1:0] select the bus (bit 0 = bus 0, bit 1 = bus 1). Bits [3:2] select the kind (bit 2 = fetch, bit 3 = data access). Bits [5:4] select the direction (bit 4 = read, bit 5 = write). A cycle qualifies only if the bit for its own option is set, and a field of 11 accepts both options.
- R4: If any one of a channel's three qualifier fields is 00, that channel never matches.
- R5: Channel B matches only when the bus data equals its data register in every bit whose data-mask bit is 0. Channel A ignores bus data.
- R6: A match sets a sticky flag at bit ch*2+bus of the flag register (bit 0 = A/bus 0, bit 1 = A/bus 1, bit 2 = B/bus 0, bit 3 = B/bus 1). The flag is visible one cycle after the cycle is sampled.
- R7: Writing the flag register clears each flag whose write-data bit is 0, and leaves each flag whose write-data bit is 1 unchanged. A match in the same cycle as a clear wins.
- R8: A match sampled on a clock edge while no request is pending drives `brk_req` high for exactly one cycle, starting right after that edge.
- R9: Matches sampled in the cycle of a pulse and in the two cycles after it issue no new request, but they still set flags. Matches on both channels in one cycle give a single request.
- R10: Register map (cfg_addr): 0 A address, 1 A address mask, 2 A qualifier, 3 B address, 4 B address mask, 5 B qualifier, 6 B data, 7 B data mask, 8 flags. Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| bus0_valid | input | 1 | Bus 0 cycle valid |
| bus0_addr | input | 32 | Bus 0 address |
| bus0_data | input | 32 | Bus 0 data |
| bus0_fetch | input | 1 | Bus 0: 1 = instruction fetch, 0 = data access |
| bus0_write | input | 1 | Bus 0: 1 = write, 0 = read |
| bus1_valid | input | 1 | Bus 1 cycle valid |
| bus1_addr | input | 32 | Bus 1 address |
| bus1_data | input | 32 | Bus 1 data |
| bus1_fetch | input | 1 | Bus 1: 1 = instruction fetch, 0 = data access |
| bus1_write | input | 1 | Bus 1: 1 = write, 0 = read |
| brk_req | output | 1 | One-cycle break request pulse |

## Verification
The address compare is driven with addresses that differ from the target only in masked bits and then in an unmasked bit, which shows that the mask picks out don't-care bits. Each qualifier field is tried with a cycle of the wrong bus, kind and direction, then opened to 11, and then set to zero one field at a time, so a missed option bit is told apart from a wrong disable. Channel B gets data that differs in masked and in unmasked bits. A burst of five back-to-back matches, a data-access match followed by a fetch match on the other channel, and simultaneous matches together show the pulse spacing and that the flags keep recording while a request is suppressed. The flag clears are checked with mixed write patterns and against a match in the same cycle.

// File: rtl/brk_pkg.sv
package brk_pkg;
    parameter int ADDR_W   = 32;
    parameter int DATA_W   = 32;
    parameter int NUM_BUS  = 2;
    parameter int NUM_CH   = 2;
    parameter int HOLD_CYC = 2;
    parameter int CFG_AW   = 4;

    localparam int REG_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int QUAL_W = 6;
    localparam int FLAG_W = NUM_CH * NUM_BUS;

    // qualifier field base positions
    localparam int FLD_BUS  = 0;
    localparam int FLD_KIND = 2;
    localparam int FLD_DIR  = 4;

    localparam int CH_A = 0;
    localparam int CH_B = 1;

    // register offsets
    localparam logic [CFG_AW-1:0] RA_A_ADDR  = CFG_AW'(0);
    localparam logic [CFG_AW-1:0] RA_A_AMASK = CFG_AW'(1);
    localparam logic [CFG_AW-1:0] RA_A_QUAL  = CFG_AW'(2);
    localparam logic [CFG_AW-1:0] RA_B_ADDR  = CFG_AW'(3);
    localparam logic [CFG_AW-1:0] RA_B_AMASK = CFG_AW'(4);
    localparam logic [CFG_AW-1:0] RA_B_QUAL  = CFG_AW'(5);
    localparam logic [CFG_AW-1:0] RA_B_DATA  = CFG_AW'(6);
    localparam logic [CFG_AW-1:0] RA_B_DMASK = CFG_AW'(7);
    localparam logic [CFG_AW-1:0] RA_FLAGS   = CFG_AW'(8);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              fetch;
        logic              write;
    } bus_cyc_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] amask;
        logic [QUAL_W-1:0] qual;
    } match_reg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] amask;
        logic [QUAL_W-1:0] qual;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] dmask;
    } chan_cfg_t;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CFG_AW-1:0]        addr,
    input  logic [REG_W-1:0]         wdata,
    output logic [REG_W-1:0]         rdata,
    input  logic [FLAG_W-1:0]        hit,
    output chan_cfg_t [NUM_CH-1:0]   cfg
);
    typedef struct packed {
        match_reg_t [NUM_CH-1:0] ch;
        logic [DATA_W-1:0]       bdata;
        logic [DATA_W-1:0]       bdmask;
        logic [FLAG_W-1:0]       flags;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (addr)
                RA_A_ADDR:  r_d.ch[CH_A].addr  = wdata[ADDR_W-1:0];
                RA_A_AMASK: r_d.ch[CH_A].amask = wdata[ADDR_W-1:0];
                RA_A_QUAL:  r_d.ch[CH_A].qual  = wdata[QUAL_W-1:0];
                RA_B_ADDR:  r_d.ch[CH_B].addr  = wdata[ADDR_W-1:0];
                RA_B_AMASK: r_d.ch[CH_B].amask = wdata[ADDR_W-1:0];
                RA_B_QUAL:  r_d.ch[CH_B].qual  = wdata[QUAL_W-1:0];
                RA_B_DATA:  r_d.bdata          = wdata[DATA_W-1:0];
                RA_B_DMASK: r_d.bdmask         = wdata[DATA_W-1:0];
                RA_FLAGS:   r_d.flags          = r_q.flags & wdata[FLAG_W-1:0];
                default: ;
            endcase
        end
        // a fresh match outranks a clear in the same cycle
        r_d.flags = r_d.flags | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (addr)
            RA_A_ADDR:  rdata = REG_W'(r_q.ch[CH_A].addr);
            RA_A_AMASK: rdata = REG_W'(r_q.ch[CH_A].amask);
            RA_A_QUAL:  rdata = REG_W'(r_q.ch[CH_A].qual);
            RA_B_ADDR:  rdata = REG_W'(r_q.ch[CH_B].addr);
            RA_B_AMASK: rdata = REG_W'(r_q.ch[CH_B].amask);
            RA_B_QUAL:  rdata = REG_W'(r_q.ch[CH_B].qual);
            RA_B_DATA:  rdata = REG_W'(r_q.bdata);
            RA_B_DMASK: rdata = REG_W'(r_q.bdmask);
            RA_FLAGS:   rdata = REG_W'(r_q.flags);
            default:    rdata = '0;
        endcase
    end

    // channel config out; only channel B owns data registers
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
            assign cfg[c].addr  = r_q.ch[c].addr;
            assign cfg[c].amask = r_q.ch[c].amask;
            assign cfg[c].qual  = r_q.ch[c].qual;
            if (c == CH_B) begin : g_data
                assign cfg[c].data  = r_q.bdata;
                assign cfg[c].dmask = r_q.bdmask;
            end else begin : g_nodata
                assign cfg[c].data  = '0;
                assign cfg[c].dmask = '1;
            end
        end
    endgenerate

    generate
        for (genvar i = 0; i < FLAG_W; i++) begin : g_flag_chk
            AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
                hit[i] |=> r_q.flags[i]); // R6
            AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                r_q.flags[i] && !(wr_en && addr == RA_FLAGS && !wdata[i]) |=> r_q.flags[i]); // R7
            AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en && addr == RA_FLAGS && !wdata[i] && !hit[i] |=> !r_q.flags[i]); // R7
        end
    endgenerate
endmodule

// File: rtl/brk_chan.sv
module brk_chan
    import brk_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  chan_cfg_t                  cfg,
    input  bus_cyc_t [NUM_BUS-1:0]     bus,
    output logic [NUM_BUS-1:0]         hit
);
    logic armed;

    assign armed = (|cfg.qual[FLD_BUS+:2]) && (|cfg.qual[FLD_KIND+:2]) && (|cfg.qual[FLD_DIR+:2]);

    generate
        for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
            logic addr_ok, data_ok, kind_ok, dir_ok, port_ok;

            always_comb begin
                addr_ok = ((bus[b].addr ^ cfg.addr) & ~cfg.amask) == '0;
                data_ok = ((bus[b].data ^ cfg.data) & ~cfg.dmask) == '0;
                kind_ok = bus[b].fetch ? cfg.qual[FLD_KIND] : cfg.qual[FLD_KIND+1];
                dir_ok  = bus[b].write ? cfg.qual[FLD_DIR+1] : cfg.qual[FLD_DIR];
                port_ok = cfg.qual[FLD_BUS+b];
                hit[b]  = armed && bus[b].valid && port_ok && kind_ok && dir_ok
                          && addr_ok && data_ok;
            end

            AST_HIT_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                hit[b] |-> bus[b].valid); // R6
        end
    endgenerate

    AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.qual[1:0] == 2'b00 || cfg.qual[3:2] == 2'b00 || cfg.qual[5:4] == 2'b00)
        |-> hit == '0); // R4
endmodule

// File: rtl/brk_req.sv
module brk_req
    import brk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_hit,
    output logic req
);
    localparam int CNT_W = $clog2(HOLD_CYC + 2);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC + 1);

    typedef struct packed {
        logic             req;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.req = 1'b0;
        if (s_q.cnt != '0) s_d.cnt = s_q.cnt - 1'b1;
        if (any_hit && s_q.cnt == '0) begin
            s_d.req = 1'b1;
            s_d.cnt = CNT_LOAD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req = s_q.req;

    // spacing checker: cycles since the last pulse, saturating
    logic [CNT_W-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n)               gap_q <= CNT_LOAD;
        else if (s_q.req)         gap_q <= '0;
        else if (gap_q != CNT_LOAD) gap_q <= gap_q + 1'b1;
    end

    AST_REQ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> gap_q == CNT_LOAD); // R9
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req); // R8
    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(any_hit)); // R8
endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
    import brk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    input  logic                 bus0_valid,
    input  logic [ADDR_W-1:0]    bus0_addr,
    input  logic [DATA_W-1:0]    bus0_data,
    input  logic                 bus0_fetch,
    input  logic                 bus0_write,
    input  logic                 bus1_valid,
    input  logic [ADDR_W-1:0]    bus1_addr,
    input  logic [DATA_W-1:0]    bus1_data,
    input  logic                 bus1_fetch,
    input  logic                 bus1_write,
    output logic                 brk_req
);
    bus_cyc_t [NUM_BUS-1:0]             bus;
    chan_cfg_t [NUM_CH-1:0]             cfg;
    logic [NUM_CH-1:0][NUM_BUS-1:0]     hit2d;
    logic [FLAG_W-1:0]                  hit_flat;

    assign bus[0] = {bus0_valid, bus0_addr, bus0_data, bus0_fetch, bus0_write};
    assign bus[1] = {bus1_valid, bus1_addr, bus1_data, bus1_fetch, bus1_write};
    assign hit_flat = hit2d;

    brk_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .hit   (hit_flat),
        .cfg   (cfg)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            brk_chan u_chan (
                .clk   (clk),
                .rst_n (rst_n),
                .cfg   (cfg[c]),
                .bus   (bus),
                .hit   (hit2d[c])
            );
        end
    endgenerate

    brk_req u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_hit (|hit_flat),
        .req     (brk_req)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) $past(!rst_n) |-> !brk_req); // R1
endmodule

// File: tb/sim_bus_break_unit.sv
`timescale 1ns/1ps
module sim_bus_break_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        bus0_valid = 1'b0, bus0_fetch = 1'b0, bus0_write = 1'b0;
    logic [31:0] bus0_addr = '0, bus0_data = '0;
    logic        bus1_valid = 1'b0, bus1_fetch = 1'b0, bus1_write = 1'b0;
    logic [31:0] bus1_addr = '0, bus1_data = '0;
    logic        brk_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam int O_AADDR = 0, O_AMASK = 1, O_AQUAL = 2, O_BADDR = 3, O_BMASK = 4,
                   O_BQUAL = 5, O_BDATA = 6, O_BDMSK = 7, O_FLAGS = 8;

    always #2.5 clk = ~clk;

    bus_break_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus0_valid(bus0_valid), .bus0_addr(bus0_addr), .bus0_data(bus0_data),
        .bus0_fetch(bus0_fetch), .bus0_write(bus0_write),
        .bus1_valid(bus1_valid), .bus1_addr(bus1_addr), .bus1_data(bus1_data),
        .bus1_fetch(bus1_fetch), .bus1_write(bus1_write),
        .brk_req(brk_req)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input int a, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
        cfg_addr = 4'(a);
        #0.5;
        check(tag, cfg_rdata, exp);
    endtask

    task automatic put0(input logic [31:0] a, input logic [31:0] d, input logic f, input logic w);
        bus0_valid = 1'b1; bus0_addr = a; bus0_data = d; bus0_fetch = f; bus0_write = w;
    endtask

    task automatic put1(input logic [31:0] a, input logic [31:0] d, input logic f, input logic w);
        bus1_valid = 1'b1; bus1_addr = a; bus1_data = d; bus1_fetch = f; bus1_write = w;
    endtask

    task automatic tick(output logic r);
        @(negedge clk);
        r = brk_req;
        bus0_valid = 1'b0;
        bus1_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic r;
        check("R1 req after reset", {31'b0, brk_req}, 32'h0);
        for (int a = 0; a < 9; a++) rd_chk("R1 register reset value", a, 32'h0);
        rd_chk("R10 unmapped offset", 12, 32'h0);
        put0(32'h0, 32'h0, 1'b1, 1'b0);
        tick(r);
        check("R4 disarmed after reset", {31'b0, r}, 32'h0);
        rd_chk("R4 no flags while disarmed", O_FLAGS, 32'h0);
    endtask

    task automatic t_addr();
        logic r;
        wr(O_AADDR, 32'h1000_0040);
        wr(O_AMASK, 32'h0000_000F);
        wr(O_AQUAL, 32'h15);
        rd_chk("R10 A address", O_AADDR, 32'h1000_0040);
        rd_chk("R10 A mask", O_AMASK, 32'h0000_000F);
        rd_chk("R10 A qualifier", O_AQUAL, 32'h15);
        put0(32'h1000_0047, 32'h1234_5678, 1'b1, 1'b0);
        tick(r);
        check("R2 masked-bit match raises request", {31'b0, r}, 32'h1);
        tick(r);
        check("R8 request is one cycle", {31'b0, r}, 32'h0);
        rd_chk("R6 flag A bus0", O_FLAGS, 32'h1);
        wr(O_FLAGS, 32'h0);
        idle(4);
        put0(32'h1000_0050, 32'h0, 1'b1, 1'b0);
        tick(r);
        check("R2 unmasked bit differs", {31'b0, r}, 32'h0);
        put0(32'h1000_0040, 32'hDEAD_BEEF, 1'b1, 1'b0);
        tick(r);
        check("R5 channel A ignores data", {31'b0, r}, 32'h1);
        idle(4);
        wr(O_FLAGS, 32'h0);
    endtask

    task automatic t_qual();
        logic r;
        put1(32'h1000_0040, 32'h0, 1'b1, 1'b0);
        tick(r);
        check("R3 wrong bus rejected", {31'b0, r}, 32'h0);
        put0(32'h1000_0040, 32'h0, 1'b0, 1'b0);
        tick(r);
        check("R3 data access rejected by fetch-only", {31'b0, r}, 32'h0);
        put0(32'h1000_0040, 32'h0, 1'b1, 1'b1);
        tick(r);
        check("R3 write rejected by read-only", {31'b0, r}, 32'h0);
        rd_chk("R3 no flags from rejected cycles", O_FLAGS, 32'h0);
        wr(O_AQUAL, 32'h3F);
        put1(32'h1000_0041, 32'h0, 1'b0, 1'b1);
        tick(r);
        check("R3 field 11 accepts both options", {31'b0, r}, 32'h1);
        rd_chk("R6 flag A bus1", O_FLAGS, 32'h2);
        idle(4);
        wr(O_FLAGS, 32'h0);
    endtask

    task automatic t_disable();
        logic r;
        logic [31:0] quals [3] = '{32'h3C, 32'h33, 32'h0F};
        foreach (quals[k]) begin
            wr(O_AQUAL, quals[k]);
            put0(32'h1000_0040, 32'h0, 1'b1, 1'b0);
            put1(32'h1000_0040, 32'h0, 1'b0, 1'b1);
            tick(r);
            check($sformatf("R4 zero field disables (qual %0h)", quals[k]), {31'b0, r}, 32'h0);
        end
        rd_chk("R4 no flags while disabled", O_FLAGS, 32'h0);
        wr(O_AQUAL, 32'h0);
    endtask

    task automatic t_data();
        logic r;
        wr(O_BADDR, 32'h2000_0000);
        wr(O_BMASK, 32'h0);
        wr(O_BQUAL, 32'h2A);
        wr(O_BDATA, 32'hCAFE_0000);
        wr(O_BDMSK, 32'h0000_FFFF);
        rd_chk("R10 B data", O_BDATA, 32'hCAFE_0000);
        rd_chk("R10 B data mask", O_BDMSK, 32'h0000_FFFF);
        rd_chk("R10 B qualifier", O_BQUAL, 32'h2A);
        put1(32'h2000_0000, 32'hCAFE_1234, 1'b0, 1'b1);
        tick(r);
        check("R5 data match under mask", {31'b0, r}, 32'h1);
        rd_chk("R6 flag B bus1", O_FLAGS, 32'h8);
        idle(4);
        put1(32'h2000_0000, 32'hCAFF_1234, 1'b0, 1'b1);
        tick(r);
        check("R5 unmasked data bit differs", {31'b0, r}, 32'h0);
        wr(O_FLAGS, 32'h0);
    endtask

    task automatic t_clear();
        logic r;
        wr(O_AADDR, 32'h0);
        wr(O_AMASK, 32'hFFFF_FFFF);
        wr(O_AQUAL, 32'h3F);
        put0(32'h5555_0000, 32'h0, 1'b1, 1'b0);
        put1(32'h2000_0000, 32'hCAFE_0000, 1'b0, 1'b1);
        tick(r);
        check("R9 simultaneous matches one request", {31'b0, r}, 32'h1);
        tick(r);
        check("R9 no second request", {31'b0, r}, 32'h0);
        rd_chk("R6 three flags set", O_FLAGS, 32'hB);
        idle(3);
        wr(O_FLAGS, 32'hFFFF_FFFE);
        rd_chk("R7 zero bit clears one flag", O_FLAGS, 32'hA);
        wr(O_FLAGS, 32'h0000_000F);
        rd_chk("R7 ones leave flags", O_FLAGS, 32'hA);
        cfg_wr = 1'b1; cfg_addr = 4'(O_FLAGS); cfg_wdata = 32'h0;
        put0(32'h0, 32'h0, 1'b1, 1'b0);
        tick(r);
        cfg_wr = 1'b0;
        rd_chk("R7 match wins over clear", O_FLAGS, 32'h1);
        wr(O_AQUAL, 32'h0);
        idle(4);
        wr(O_FLAGS, 32'h0);
    endtask

    task automatic t_merge();
        logic r;
        logic [4:0] exp_seq = 5'b10001;
        wr(O_AADDR, 32'h3000_0000);
        wr(O_AMASK, 32'h0);
        wr(O_AQUAL, 32'h19);
        wr(O_BADDR, 32'h3000_0004);
        wr(O_BQUAL, 32'h16);
        wr(O_BDMSK, 32'hFFFF_FFFF);
        put0(32'h3000_0000, 32'h0, 1'b0, 1'b0);
        tick(r);
        check("R9 data access match requests", {31'b0, r}, 32'h1);
        put1(32'h3000_0004, 32'h0, 1'b1, 1'b0);
        tick(r);
        check("R9 following fetch merged", {31'b0, r}, 32'h0);
        rd_chk("R9 both channels flagged", O_FLAGS, 32'h9);
        idle(4);
        for (int k = 0; k < 5; k++) begin
            put0(32'h3000_0000, 32'h0, 1'b0, 1'b0);
            tick(r);
            check($sformatf("R9 burst cycle %0d", k), {31'b0, r}, {31'b0, exp_seq[k]});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr();
        t_qual();
        t_disable();
        t_data();
        t_clear();
        t_merge();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired got 1 exp 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule